// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block watches over software by counting on a slow counter clock that is asynchronous to the register bus clock. After software enables it, the counter runs without stopping toward a programmed time-out. Software must service it by writing a key to the service register before the time-out ends. If it does not, the block raises a system reset request. In window mode, a closed interval comes first, and a service that arrives during it is treated as a fault. An early-warning flag, with a level interrupt, can tell software that the time-out is getting close.

Software writes to the control, configuration, warning and service registers in the bus domain. One write at a time crosses into the counter domain through a toggle-and-acknowledge handshake. A busy bit covers the whole transfer, and writes made while it is set are dropped. An external protect input blocks writes to every register except the flag register, unless the write is marked as coming from a debugger. A debug-halt input, synchronous to the counter clock, freezes the count.

The counter-domain state machine has four states. In `ST_OFF` it is disabled. In `ST_SHUT` the window is closed. In `ST_OPEN` servicing is allowed. In `ST_FIRE` the reset request is raised. The transitions are:
- OFF→SHUT or OFF→OPEN on enable, depending on the mode bit.
- SHUT→OPEN when the closed interval ends.
- OPEN→FIRE when the period expires.
- SHUT→FIRE on an early service.
- SHUT→FIRE or OPEN→FIRE on a wrong key.
- OPEN→SHUT or OPEN→OPEN on a good service.
- Any running state→OFF on disable.
- FIRE is left only by reset.

Top module: `wdw_timer`

## Requirements
- R1: After reset, `rst_req`, `irq_warn` and `sync_busy` are 0, and every register reads 0.
- R2: The register map is: address 0 control (bit0 enable, bit1 window mode), 1 configuration (bits 3:0 period selector, bits 7:4 window selector), 2 warning offset selector (bits 3:0), 3 interrupt-enable set, 4 interrupt-enable clear (bit0 of each; both read back the enable), 5 warning flag, 6 service, 7 status (bit0 busy). In normal mode with no service, `rst_req` rises once the period has elapsed after enable.
- R3: Writing 0xA5 to the service register while the window is open restarts the count from 0, so regular service keeps `rst_req` low.
- R4: Writing any value other than 0xA5 to the service register while the timer is running raises `rst_req` at once.
- R5: In window mode, a correct service during the closed interval raises `rst_req`. A correct service during the open interval restarts the closed interval.
- R6: Each selector s gives a length of 8·2^min(s,11) counter cycles, so values from 11 to 15 all give 16384.
- R7: The warning flag (address 5, bit0) is set when the open-phase count passes the warning length. It is cleared by writing 1 to bit0. `irq_warn` equals flag AND interrupt enable.
- R8: Writing 1 to bit0 of address 3 sets the interrupt enable. Writing 1 to bit0 of address 4 clears it.
- R9: `sync_busy` rises in the bus cycle after a write to address 0, 1, 2 or 6, and stays high until the counter domain has captured the value. Writes to those addresses while busy are ignored.
- R10: While `dbg_halt` is high, the count and state are frozen.
- R11: While `wprot` is high, writes are ignored except to address 5 or when `wr_dbg` is high.
- R12: Once raised, `rst_req` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Register bus clock |
| rst_bus_n | input | 1 | Bus-domain reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| wr_dbg | input | 1 | Write issued by a debugger (bypasses protection) |
| wprot | input | 1 | Write protection enable |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| sync_busy | output | 1 | Cross-domain write in flight |
| irq_warn | output | 1 | Early-warning level interrupt |
| clk_cnt | input | 1 | Slow counter clock |
| rst_cnt_n | input | 1 | Counter-domain reset, active low |
| dbg_halt | input | 1 | Debug halt, counter-clock synchronous |
| rst_req | output | 1 | System reset request, sticky |

## Verification
The bench checks several timing boundaries:
- A service a few cycles into the closed window must fire. A design that only counts the open phase would stay quiet.
- A service after the closed window must not fire. A design that never leaves SHUT would fire here.
- A wrong key must fire at once, not at the end of the period.
- A selector of 12 must clamp to 16384 cycles and not wrap to a short period.
- A configuration write made while busy must leave the old value readable.
- Writes under protection must be dropped, except a flag clear and a write marked as coming from a debugger.
- A long debug halt must not let the period expire, and the reset request must stay high once raised.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_CFG   = 3'd1,
        A_EWCFG = 3'd2,
        A_IESET = 3'd3,
        A_IECLR = 3'd4,
        A_FLAG  = 3'd5,
        A_SVC   = 3'd6,
        A_STAT  = 3'd7
    } wdw_addr_e;

    typedef enum logic [1:0] {
        K_CTRL = 2'd0,
        K_CFG  = 2'd1,
        K_EW   = 2'd2,
        K_SVC  = 2'd3
    } wdw_kind_e;

    typedef struct packed {
        wdw_kind_e  kind;
        logic [7:0] data;
    } wdw_cmd_t;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_SHUT = 2'd1,
        ST_OPEN = 2'd2,
        ST_FIRE = 2'd3
    } wdw_state_e;

    localparam logic [7:0] SVC_KEY = 8'hA5;
endpackage

// File: rtl/wdw_sync2.sv
module wdw_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wdw_regs.sv
module wdw_regs
    import wdw_pkg::*;
#(
    parameter int AW = 3,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_dbg,
    input  logic          wprot,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          ack_s,
    input  logic          warn_s,
    output logic          req_tgl,
    output wdw_cmd_t      cmd,
    output logic          busy,
    output logic          irq
);
    localparam int SELW = 4;

    logic            en_q, win_q, ie_q, flag_q, warn_d;
    logic [DW-1:0]   cfg_q;
    logic [SELW-1:0] ew_q;
    logic            wr_ok, is_sync, take_sync, warn_set;
    wdw_addr_e       wa;
    wdw_kind_e       kind_c;

    assign wa       = wdw_addr_e'(wr_addr);
    assign busy     = req_tgl ^ ack_s;
    assign wr_ok    = wr_en && (!wprot || wr_dbg || wa == A_FLAG);
    assign warn_set = warn_s ^ warn_d;

    always_comb begin
        is_sync = 1'b1;
        kind_c  = K_CTRL;
        unique case (wa)
            A_CTRL:  kind_c = K_CTRL;
            A_CFG:   kind_c = K_CFG;
            A_EWCFG: kind_c = K_EW;
            A_SVC:   kind_c = K_SVC;
            default: is_sync = 1'b0;
        endcase
    end

    assign take_sync = wr_ok && is_sync && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_tgl <= 1'b0;
            cmd     <= '{kind: K_CTRL, data: '0};
            en_q    <= 1'b0;
            win_q   <= 1'b0;
            cfg_q   <= '0;
            ew_q    <= '0;
            ie_q    <= 1'b0;
            flag_q  <= 1'b0;
            warn_d  <= 1'b0;
        end else begin
            warn_d <= warn_s;
            if (take_sync) begin
                req_tgl   <= ~req_tgl;
                cmd.kind  <= kind_c;
                cmd.data  <= wr_data;
                if (wa == A_CTRL) begin
                    en_q  <= wr_data[0];
                    win_q <= wr_data[1];
                end
                if (wa == A_CFG)   cfg_q <= wr_data;
                if (wa == A_EWCFG) ew_q  <= wr_data[SELW-1:0];
            end
            if (wr_ok && wa == A_IESET && wr_data[0]) ie_q <= 1'b1;
            if (wr_ok && wa == A_IECLR && wr_data[0]) ie_q <= 1'b0;
            if (warn_set)
                flag_q <= 1'b1;
            else if (wr_ok && wa == A_FLAG && wr_data[0])
                flag_q <= 1'b0;
        end
    end

    assign irq = flag_q & ie_q;

    always_comb begin
        rd_data = '0;
        unique case (wdw_addr_e'(rd_addr))
            A_CTRL:  rd_data = {{(DW-2){1'b0}}, win_q, en_q};
            A_CFG:   rd_data = cfg_q;
            A_EWCFG: rd_data = {{(DW-SELW){1'b0}}, ew_q};
            A_IESET: rd_data = {{(DW-1){1'b0}}, ie_q};
            A_IECLR: rd_data = {{(DW-1){1'b0}}, ie_q};
            A_FLAG:  rd_data = {{(DW-1){1'b0}}, flag_q};
            A_SVC:   rd_data = '0;
            A_STAT:  rd_data = {{(DW-1){1'b0}}, busy};
        endcase
    end
endmodule

// File: rtl/wdw_core.sv
module wdw_core
    import wdw_pkg::*;
#(
    parameter int BASE_LOG = 3,
    parameter int MAX_SEL  = 11,
    parameter int SELW     = 4,
    localparam int CW      = BASE_LOG + MAX_SEL
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_s,
    input  wdw_cmd_t   cmd,
    input  logic       dbg_halt,
    output logic       ack,
    output logic       warn_tgl,
    output logic       rst_req,
    output logic       apply_o,
    output logic [CW-1:0] cnt_o,
    output wdw_state_e st_o
);
    wdw_state_e      st, nxt;
    logic [CW-1:0]   cnt, cnt_n;
    logic            en_q, win_q, en_n, win_n;
    logic [SELW-1:0] per_sel, win_sel, ew_sel;
    logic [SELW-1:0] per_sel_n, win_sel_n, ew_sel_n;
    logic            req_d, apply, warn_pulse;
    logic [CW-1:0]   per_last, win_last, ew_last;

    function automatic logic [CW-1:0] last_of(input logic [SELW-1:0] sel);
        logic [CW:0] one_sh;
        int          sh;
        sh     = (int'(sel) > MAX_SEL) ? MAX_SEL : int'(sel);
        one_sh = {{CW{1'b0}}, 1'b1} << (BASE_LOG + sh);
        return one_sh[CW-1:0] - {{(CW-1){1'b0}}, 1'b1};
    endfunction

    assign apply    = req_s ^ req_d;
    assign per_last = last_of(per_sel);
    assign win_last = last_of(win_sel);
    assign ew_last  = last_of(ew_sel);

    always_comb begin
        nxt        = st;
        cnt_n      = cnt;
        en_n       = en_q;
        win_n      = win_q;
        per_sel_n  = per_sel;
        win_sel_n  = win_sel;
        ew_sel_n   = ew_sel;
        warn_pulse = 1'b0;
        if (apply) begin
            unique case (cmd.kind)
                K_CTRL: begin
                    en_n  = cmd.data[0];
                    win_n = cmd.data[1];
                    if (st != ST_FIRE) begin
                        if (!cmd.data[0]) begin
                            nxt   = ST_OFF;
                            cnt_n = '0;
                        end else if (st == ST_OFF) begin
                            nxt   = cmd.data[1] ? ST_SHUT : ST_OPEN;
                            cnt_n = '0;
                        end
                    end
                end
                K_CFG: begin
                    per_sel_n = cmd.data[SELW-1:0];
                    win_sel_n = cmd.data[2*SELW-1:SELW];
                end
                K_EW: ew_sel_n = cmd.data[SELW-1:0];
                K_SVC: begin
                    if (st == ST_SHUT || st == ST_OPEN) begin
                        if (cmd.data != SVC_KEY || st == ST_SHUT) begin
                            nxt = ST_FIRE;
                        end else begin
                            cnt_n = '0;
                            nxt   = win_q ? ST_SHUT : ST_OPEN;
                        end
                    end
                end
            endcase
        end else if (!dbg_halt) begin
            unique case (st)
                ST_OFF:  ;
                ST_SHUT: begin
                    if (cnt == win_last) begin
                        nxt   = ST_OPEN;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                ST_OPEN: begin
                    if (cnt == per_last) begin
                        nxt = ST_FIRE;
                    end else begin
                        cnt_n = cnt + 1'b1;
                        if (cnt == ew_last && ew_last < per_last)
                            warn_pulse = 1'b1;
                    end
                end
                ST_FIRE: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_OFF;
            cnt     <= '0;
            en_q    <= 1'b0;
            win_q   <= 1'b0;
            per_sel <= '0;
            win_sel <= '0;
            ew_sel  <= '0;
            req_d   <= 1'b0;
        end else begin
            st      <= nxt;
            cnt     <= cnt_n;
            en_q    <= en_n;
            win_q   <= win_n;
            per_sel <= per_sel_n;
            win_sel <= win_sel_n;
            ew_sel  <= ew_sel_n;
            req_d   <= req_s;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req  <= 1'b0;
            warn_tgl <= 1'b0;
        end else begin
            rst_req  <= (nxt == ST_FIRE);
            warn_tgl <= warn_tgl ^ warn_pulse;
        end
    end

    assign ack     = req_d;
    assign apply_o = apply;
    assign cnt_o   = cnt;
    assign st_o    = st;
endmodule

// File: rtl/wdw_timer.sv
module wdw_timer
    import wdw_pkg::*;
#(
    parameter int AW       = 3,
    parameter int DW       = 8,
    parameter int BASE_LOG = 3,
    parameter int MAX_SEL  = 11,
    parameter int SYNC_STG = 2,
    localparam int CW      = BASE_LOG + MAX_SEL
) (
    input  logic          clk_bus,
    input  logic          rst_bus_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_dbg,
    input  logic          wprot,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          sync_busy,
    output logic          irq_warn,
    input  logic          clk_cnt,
    input  logic          rst_cnt_n,
    input  logic          dbg_halt,
    output logic          rst_req
);
    logic          req_tgl, req_s, ack, ack_s, warn_tgl, warn_s;
    logic          c_apply;
    logic [CW-1:0] c_cnt;
    wdw_state_e    c_state;
    wdw_cmd_t      cmd;

    wdw_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk_bus), .rst_n(rst_bus_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_dbg(wr_dbg), .wprot(wprot),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .ack_s(ack_s), .warn_s(warn_s),
        .req_tgl(req_tgl), .cmd(cmd), .busy(sync_busy), .irq(irq_warn)
    );

    wdw_sync2 #(.STAGES(SYNC_STG)) u_req_sync (
        .clk(clk_cnt), .rst_n(rst_cnt_n), .d(req_tgl), .q(req_s));
    wdw_sync2 #(.STAGES(SYNC_STG)) u_ack_sync (
        .clk(clk_bus), .rst_n(rst_bus_n), .d(ack), .q(ack_s));
    wdw_sync2 #(.STAGES(SYNC_STG)) u_warn_sync (
        .clk(clk_bus), .rst_n(rst_bus_n), .d(warn_tgl), .q(warn_s));

    wdw_core #(.BASE_LOG(BASE_LOG), .MAX_SEL(MAX_SEL)) u_core (
        .clk(clk_cnt), .rst_n(rst_cnt_n),
        .req_s(req_s), .cmd(cmd), .dbg_halt(dbg_halt),
        .ack(ack), .warn_tgl(warn_tgl), .rst_req(rst_req),
        .apply_o(c_apply), .cnt_o(c_cnt), .st_o(c_state)
    );
endmodule

// File: rtl/wdw_chk.sv
module wdw_chk
    import wdw_pkg::*;
#(
    parameter int CW = 14
) (
    input logic          clk_bus,
    input logic          rst_bus_n,
    input logic          clk_cnt,
    input logic          rst_cnt_n,
    input logic          dbg_halt,
    input logic          rst_req,
    input logic          sync_busy,
    input logic          c_apply,
    input logic [CW-1:0] c_cnt,
    input wdw_state_e    c_state,
    input wdw_cmd_t      cmd
);
    a_r12_hold_rst: assert property (@(posedge clk_cnt) disable iff (!rst_cnt_n)
        rst_req |=> rst_req);

    a_r10_halt_freeze: assert property (@(posedge clk_cnt) disable iff (!rst_cnt_n)
        (dbg_halt && !c_apply) |=> ($stable(c_cnt) && $stable(c_state)));

    a_r5_early_service: assert property (@(posedge clk_cnt) disable iff (!rst_cnt_n)
        (c_apply && cmd.kind == K_SVC && c_state == ST_SHUT) |=> rst_req);

    a_r4_bad_key: assert property (@(posedge clk_cnt) disable iff (!rst_cnt_n)
        (c_apply && cmd.kind == K_SVC && cmd.data != SVC_KEY && c_state == ST_OPEN)
        |=> rst_req);

    a_r3_restart: assert property (@(posedge clk_cnt) disable iff (!rst_cnt_n)
        (c_apply && cmd.kind == K_SVC && cmd.data == SVC_KEY && c_state == ST_OPEN)
        |=> (c_cnt == '0));

    a_r9_cmd_stable: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        sync_busy |=> $stable(cmd));
endmodule

bind wdw_timer wdw_chk #(.CW(CW)) u_chk (
    .clk_bus(clk_bus), .rst_bus_n(rst_bus_n),
    .clk_cnt(clk_cnt), .rst_cnt_n(rst_cnt_n),
    .dbg_halt(dbg_halt), .rst_req(rst_req), .sync_busy(sync_busy),
    .c_apply(c_apply), .c_cnt(c_cnt), .c_state(c_state), .cmd(cmd)
);

// File: tb/test_wdw_timer.sv
module test_wdw_timer;
    logic       clk_bus = 1'b0, clk_cnt = 1'b0;
    logic       rst_bus_n = 1'b0, rst_cnt_n = 1'b0;
    logic       wr_en = 1'b0, wr_dbg = 1'b0, wprot = 1'b0, dbg_halt = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       sync_busy, irq_warn, rst_req;

    always #5  clk_bus = ~clk_bus;
    always #15 clk_cnt = ~clk_cnt;

    wdw_timer i_wdw_timer (
        .clk_bus(clk_bus), .rst_bus_n(rst_bus_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_dbg(wr_dbg), .wprot(wprot),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .sync_busy(sync_busy), .irq_warn(irq_warn),
        .clk_cnt(clk_cnt), .rst_cnt_n(rst_cnt_n),
        .dbg_halt(dbg_halt), .rst_req(rst_req)
    );

    typedef struct { string req; logic [15:0] exp; } item_t;
    item_t       exp_q[$];
    logic [15:0] act_q[$];
    int          n_cmp = 0, n_bad = 0;
    event        got;

    function automatic void drain();
        while (act_q.size() > 0 && exp_q.size() > 0) begin
            item_t       it;
            logic [15:0] a;
            it = exp_q.pop_front();
            a  = act_q.pop_front();
            n_cmp++;
            if (a !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %0h expected %0h", it.req, a, it.exp);
            end
        end
    endfunction

    // monitor: compares results as they arrive
    initial forever begin
        @(got);
        drain();
    end

    // driver side: push expected item, then the observed value
    task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
        item_t it;
        it.req = r;
        it.exp = exp;
        exp_q.push_back(it);
        act_q.push_back(act);
        -> got;
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk_bus);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk_bus);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk_bus);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk_bus);
            if (!sync_busy) break;
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk_cnt);
    endtask

    task automatic do_reset();
        rst_bus_n = 1'b0; rst_cnt_n = 1'b0;
        cyc(3);
        rst_bus_n = 1'b1; rst_cnt_n = 1'b1;
        cyc(2);
    endtask

    task automatic sync_wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr(a, d);
        wait_idle();
    endtask

    initial begin
        #2ms;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        do_reset();
        // R1 reset state
        chk("R1 rst_req", 16'(rst_req), 0);
        chk("R1 irq", 16'(irq_warn), 0);
        bus_rd(3'd7, r); chk("R1 status", 16'(r), 0);
        bus_rd(3'd0, r); chk("R1 ctrl", 16'(r), 0);
        bus_rd(3'd1, r); chk("R1 cfg", 16'(r), 0);

        // Normal mode, period 32
        sync_wr(3'd1, 8'h02);
        bus_wr(3'd0, 8'h01);
        chk("R9 busy after write", 16'(sync_busy), 1);
        bus_wr(3'd1, 8'h55);
        wait_idle();
        chk("R9 busy clears", 16'(sync_busy), 0);
        bus_rd(3'd1, r); chk("R9 write while busy dropped", 16'(r), 16'h02);
        for (int k = 0; k < 5; k++) begin
            cyc(20);
            sync_wr(3'd6, 8'hA5);
        end
        chk("R3 serviced no reset", 16'(rst_req), 0);
        cyc(20); chk("R2 before period", 16'(rst_req), 0);
        cyc(25); chk("R2 after period", 16'(rst_req), 1);
        cyc(10); chk("R12 sticky", 16'(rst_req), 1);

        // Period 8 (selector 0), clamp and bad key
        do_reset();
        sync_wr(3'd0, 8'h01);
        cyc(3);  chk("R6 sel0 early", 16'(rst_req), 0);
        cyc(8);  chk("R6 sel0 expired", 16'(rst_req), 1);
        do_reset();
        sync_wr(3'd1, 8'h0C);
        sync_wr(3'd0, 8'h01);
        cyc(300); chk("R6 sel12 clamps long", 16'(rst_req), 0);
        sync_wr(3'd6, 8'h5A);
        cyc(2);  chk("R4 bad key", 16'(rst_req), 1);

        // Window mode: closed 16, open 16
        do_reset();
        sync_wr(3'd1, 8'h11);
        sync_wr(3'd0, 8'h03);
        cyc(4);
        sync_wr(3'd6, 8'hA5);
        cyc(2);  chk("R5 closed-window service", 16'(rst_req), 1);
        do_reset();
        sync_wr(3'd1, 8'h11);
        sync_wr(3'd0, 8'h03);
        cyc(22);
        sync_wr(3'd6, 8'hA5);
        cyc(2);  chk("R5 open-window service", 16'(rst_req), 0);
        cyc(8);
        sync_wr(3'd6, 8'hA5);
        cyc(2);  chk("R5 service re-closes window", 16'(rst_req), 1);

        // Early warning: period 32, warning 8
        do_reset();
        sync_wr(3'd1, 8'h02);
        sync_wr(3'd2, 8'h00);
        bus_wr(3'd3, 8'h01);
        sync_wr(3'd0, 8'h01);
        cyc(2);
        bus_rd(3'd5, r); chk("R7 flag not yet", 16'(r), 0);
        cyc(14);
        bus_rd(3'd5, r); chk("R7 flag set", 16'(r), 1);
        chk("R7 irq", 16'(irq_warn), 1);
        bus_wr(3'd4, 8'h01);
        bus_rd(3'd3, r); chk("R8 enable cleared", 16'(r), 0);
        chk("R8 irq off", 16'(irq_warn), 0);
        bus_wr(3'd3, 8'h01);
        chk("R8 irq back", 16'(irq_warn), 1);
        bus_wr(3'd5, 8'h01);
        bus_rd(3'd5, r); chk("R7 flag W1C", 16'(r), 0);
        chk("R7 irq after clear", 16'(irq_warn), 0);
        sync_wr(3'd6, 8'hA5);
        cyc(14);
        wprot = 1'b1;
        bus_wr(3'd5, 8'h01);
        bus_rd(3'd5, r); chk("R11 flag exempt", 16'(r), 0);
        bus_wr(3'd0, 8'h00);
        chk("R11 no busy", 16'(sync_busy), 0);
        bus_rd(3'd0, r); chk("R11 ctrl protected", 16'(r), 1);
        wr_dbg = 1'b1;
        bus_wr(3'd4, 8'h01);
        wr_dbg = 1'b0;
        bus_rd(3'd3, r); chk("R11 debugger bypass", 16'(r), 0);
        wprot = 1'b0;
        sync_wr(3'd6, 8'hA5);

        // Debug halt
        @(negedge clk_cnt); dbg_halt = 1'b1;
        cyc(100); chk("R10 halted no reset", 16'(rst_req), 0);
        dbg_halt = 1'b0;
        cyc(45); chk("R10 resumes to reset", 16'(rst_req), 1);

        #1;
        drain();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule